// File: doc/BRIEF.md
# Ternary Pattern Match Row

This block is a cycle-accurate digital model of a single ternary match row. It holds a stored pattern of `KEY_W` positions. Each position can require a 0, require a 1, accept either value, or reject every key. A search compares a key against the whole pattern at once and reports whether every position agrees.

Each position is kept as a pair of enable bits. One enable sits on the true copy of the key bit. The other sits on the complemented copy. A search has two explicit phases. First the match line is charged to its active level. Then the key drives the signal lines and any enabled element that sees its line asserted pulls the match line away.

A compile-time polarity parameter selects the line convention. The line can be charged high so that a mismatch pulls it low, or charged low so that a mismatch drives it high. The meaning of the match output is the same in both modes. A write port loads one position per cycle. A write that arrives while a search is running is held back until the search has finished.

Top module: `tpm_row`

## Requirements
- R1: After reset, `match` and `done` are 0 and `mline` sits at the opposite of the precharge level. Every position is don't-care, so the first search matches any key.
- R2: Position code bit 1 enables the element on the true line, and a key bit of 1 then causes a mismatch. Code bit 0 enables the element on the complement line, and a key bit of 0 then causes a mismatch. So code 00 is don't-care, 01 stores a 1, 10 stores a 0 and 11 never matches.
- R3: A search reports `match`=1 only when every position agrees with the key. A single disagreeing position gives `match`=0.
- R4: A don't-care position accepts either key value. A pattern of 1,0,X,1 (MSB first) matches keys 1001 and 1011 and no other key.
- R5: `start` and `key` are sampled at clock edge k. The row is in precharge after edge k and in evaluate after edge k+1. After edge k+2, `done` is 1 for exactly one cycle and `match` holds the result. `match` keeps that value until the next search completes.
- R6: With `PRECHARGE_HIGH`=1, `mline` is 1 during precharge and ends at 0 on a mismatch. With `PRECHARGE_HIGH`=0, `mline` is 0 during precharge and ends at 1 on a mismatch. After a match it stays at the precharge level.
- R7: A `start` that is seen while a search is in progress is ignored. Changes on `key` after edge k do not affect that search.
- R8: A write seen while a search is in progress does not change that search's result. It is applied at the first edge after the search completes, so the next search sees it. A write seen while idle is applied at that edge.
- R9: A position coded 11 makes every key mismatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a search when idle |
| key | input | KEY_W | Search key, sampled with start |
| wr_en | input | 1 | Write one pattern position |
| wr_idx | input | IDX_W | Position to write |
| wr_code | input | 2 | Enable pair for the position (bit 1 true line, bit 0 complement line) |
| match | output | 1 | Result of the last completed search |
| done | output | 1 | One-cycle pulse when a search completes |
| mline | output | 1 | Registered match-line level |

## Verification
The bench builds the row twice with `KEY_W`=4, once with each setting of `PRECHARGE_HIGH`. Both copies receive the same stimulus. At that width the bench can load every one of the 256 possible stored patterns, including all code-11 cases, and search each one with all 16 keys. Match results and final line levels are compared against a position-by-position computation. Directed sequences then probe the phase timing, the ignored restart, the capture of the key at the start edge and the deferral of a write issued mid-search.

// File: rtl/tpm_pkg.sv
// Package: shared types and code values for the ternary match row.
// Assumes a position code is {true-line enable, complement-line enable}.
package tpm_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_PRE  = 2'd1,
        PH_EVAL = 2'd2
    } phase_t;

    typedef logic [1:0] cell_code_t;

    localparam cell_code_t CELL_ANY   = 2'b00;
    localparam cell_code_t CELL_ONE   = 2'b01;
    localparam cell_code_t CELL_ZERO  = 2'b10;
    localparam cell_code_t CELL_NEVER = 2'b11;

endpackage

// File: rtl/tpm_pattern_store.sv
// Module: per-position enable-pair storage for one match row.
// Writes one position per cycle; resets every position to don't-care.
// Assumes the controller only asserts we_i while no search is running.
module tpm_pattern_store
    import tpm_pkg::*;
#(
    parameter int KEY_W = 16,
    parameter int IDX_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we_i,
    input  logic [IDX_W-1:0]   idx_i,
    input  cell_code_t         code_i,
    input  logic               search_busy_i,
    output logic [2*KEY_W-1:0] pattern_o
);

    for (genvar i = 0; i < KEY_W; i++) begin : g_pos
        cell_code_t cell_q;

        // Hold the enable pair of position i; cleared to don't-care at reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cell_q <= CELL_ANY;
            end else if (we_i && (idx_i == IDX_W'(i))) begin
                cell_q <= code_i;
            end
        end

        assign pattern_o[2*i +: 2] = cell_q;
    end

    // Pattern must not move while a search is in flight.
    AST_PATTERN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        search_busy_i |=> $stable(pattern_o)); // R8

endmodule

// File: rtl/tpm_mismatch_eval.sv
// Module: per-position discharge detection for one match row.
// A position pulls the line when its true-line element is enabled and the
// key bit is 1, or its complement-line element is enabled and the bit is 0.
// Assumes drive_i is high only while the signal lines carry the key.
module tpm_mismatch_eval
    import tpm_pkg::*;
#(
    parameter int KEY_W = 16
) (
    input  logic [2*KEY_W-1:0] pattern_i,
    input  logic [KEY_W-1:0]   key_i,
    input  logic               drive_i,
    output logic               any_pull_o
);

    logic [KEY_W-1:0] pull;

    for (genvar i = 0; i < KEY_W; i++) begin : g_pull
        cell_code_t code;
        assign code = pattern_i[2*i +: 2];

        // Discharge path of position i through either enabled element.
        always_comb begin
            pull[i] = drive_i & ((code[1] & key_i[i]) | (code[0] & ~key_i[i]));
        end
    end

    // Wired combination of every discharge path on the shared line.
    always_comb begin
        any_pull_o = |pull;
    end

endmodule

// File: rtl/tpm_seq_ctrl.sv
// Module: phase sequencer, match-line register and write hold-off.
// Runs idle -> precharge -> evaluate -> idle. It registers the line level
// and the result, and defers writes seen during a search.
// Assumes any_pull_i is valid in the evaluate phase for the captured key.
module tpm_seq_ctrl
    import tpm_pkg::*;
#(
    parameter int KEY_W          = 16,
    parameter int IDX_W          = 4,
    parameter bit PRECHARGE_HIGH = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [KEY_W-1:0] key_i,
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  cell_code_t       wr_code_i,
    input  logic             any_pull_i,
    output logic [KEY_W-1:0] key_q_o,
    output logic             drive_o,
    output logic             busy_o,
    output logic             mem_we_o,
    output logic [IDX_W-1:0] mem_idx_o,
    output cell_code_t       mem_code_o,
    output logic             mline_o,
    output logic             match_o,
    output logic             done_o
);

    localparam logic PRE_LVL = PRECHARGE_HIGH;
    localparam logic OFF_LVL = ~PRECHARGE_HIGH;

    phase_t           phase_q;
    logic [KEY_W-1:0] key_q;
    logic             mline_q;
    logic             match_q;
    logic             done_q;
    logic             pend_v_q;
    logic [IDX_W-1:0] pend_idx_q;
    cell_code_t       pend_code_q;
    logic             idle;
    logic             mline_next;

    // Decode the idle state used by both the sequencer and write path.
    always_comb begin
        idle = (phase_q == PH_IDLE);
    end

    // Line level at the end of evaluate: a pull moves it off precharge.
    always_comb begin
        mline_next = any_pull_i ? OFF_LVL : mline_q;
    end

    // Phase sequencer with key capture, line level, result and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            key_q   <= '0;
            mline_q <= OFF_LVL;
            match_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (phase_q)
                PH_IDLE: begin
                    if (start_i) begin
                        key_q   <= key_i;
                        mline_q <= PRE_LVL;
                        phase_q <= PH_PRE;
                    end
                end
                PH_PRE: begin
                    phase_q <= PH_EVAL;
                end
                PH_EVAL: begin
                    mline_q <= mline_next;
                    match_q <= (mline_next == PRE_LVL);
                    done_q  <= 1'b1;
                    phase_q <= PH_IDLE;
                end
                default: begin
                    phase_q <= PH_IDLE;
                end
            endcase
        end
    end

    // Hold-off buffer: capture writes during a search, drain when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_v_q    <= 1'b0;
            pend_idx_q  <= '0;
            pend_code_q <= CELL_ANY;
        end else if (!idle && wr_en_i) begin
            pend_v_q    <= 1'b1;
            pend_idx_q  <= wr_idx_i;
            pend_code_q <= wr_code_i;
        end else if (idle && pend_v_q) begin
            if (wr_en_i) begin
                pend_idx_q  <= wr_idx_i;
                pend_code_q <= wr_code_i;
            end else begin
                pend_v_q <= 1'b0;
            end
        end
    end

    // Storage write select: a deferred write goes before a new one.
    always_comb begin
        mem_we_o   = 1'b0;
        mem_idx_o  = wr_idx_i;
        mem_code_o = wr_code_i;
        if (idle && pend_v_q) begin
            mem_we_o   = 1'b1;
            mem_idx_o  = pend_idx_q;
            mem_code_o = pend_code_q;
        end else if (idle && wr_en_i) begin
            mem_we_o = 1'b1;
        end
    end

    assign key_q_o = key_q;
    assign drive_o = (phase_q == PH_EVAL);
    assign busy_o  = !idle;
    assign mline_o = mline_q;
    assign match_o = match_q;
    assign done_o  = done_q;

    AST_PRECHARGE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_PRE) |-> (mline_q == PRE_LVL)); // R6

    AST_PRE_THEN_EVAL: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_PRE) |=> (phase_q == PH_EVAL)); // R5

    AST_EVAL_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_EVAL) |=> done_q); // R5

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q); // R5

    AST_RESULT_AGREES_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (match_q == (mline_q == PRE_LVL))); // R6

    AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != PH_IDLE) |=> $stable(key_q)); // R7

endmodule

// File: rtl/tpm_row.sv
// Module: top of one ternary match row.
// Ties storage, mismatch evaluation and the phase sequencer together.
// Assumes IDX_W is wide enough to address KEY_W positions.
module tpm_row
    import tpm_pkg::*;
#(
    parameter int KEY_W          = 16,
    parameter int IDX_W          = $clog2(KEY_W),
    parameter bit PRECHARGE_HIGH = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [KEY_W-1:0] key,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [1:0]       wr_code,
    output logic             match,
    output logic             done,
    output logic             mline
);

    logic [KEY_W-1:0]   key_q;
    logic               drive;
    logic               busy;
    logic               mem_we;
    logic [IDX_W-1:0]   mem_idx;
    cell_code_t         mem_code;
    logic [2*KEY_W-1:0] pattern;
    logic               any_pull;

    tpm_seq_ctrl #(
        .KEY_W          (KEY_W),
        .IDX_W          (IDX_W),
        .PRECHARGE_HIGH (PRECHARGE_HIGH)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .key_i      (key),
        .wr_en_i    (wr_en),
        .wr_idx_i   (wr_idx),
        .wr_code_i  (wr_code),
        .any_pull_i (any_pull),
        .key_q_o    (key_q),
        .drive_o    (drive),
        .busy_o     (busy),
        .mem_we_o   (mem_we),
        .mem_idx_o  (mem_idx),
        .mem_code_o (mem_code),
        .mline_o    (mline),
        .match_o    (match),
        .done_o     (done)
    );

    tpm_pattern_store #(
        .KEY_W (KEY_W),
        .IDX_W (IDX_W)
    ) u_store (
        .clk           (clk),
        .rst_n         (rst_n),
        .we_i          (mem_we),
        .idx_i         (mem_idx),
        .code_i        (mem_code),
        .search_busy_i (busy),
        .pattern_o     (pattern)
    );

    tpm_mismatch_eval #(
        .KEY_W (KEY_W)
    ) u_eval (
        .pattern_i  (pattern),
        .key_i      (key_q),
        .drive_i    (drive),
        .any_pull_o (any_pull)
    );

endmodule

// File: tb/tb_tpm_row.sv
`timescale 1ns/1ps
module tb_tpm_row;

    localparam int KW = 4;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [KW-1:0] key = '0;
    logic          wr_en = 1'b0;
    logic [IW-1:0] wr_idx = '0;
    logic [1:0]    wr_code = '0;
    logic          match, done, mline;
    logic          match_l, done_l, mline_l;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    tpm_row #(.KEY_W(KW), .IDX_W(IW), .PRECHARGE_HIGH(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .key(key), .wr_en(wr_en),
        .wr_idx(wr_idx), .wr_code(wr_code), .match(match), .done(done), .mline(mline));

    tpm_row #(.KEY_W(KW), .IDX_W(IW), .PRECHARGE_HIGH(1'b0)) dut_low (
        .clk(clk), .rst_n(rst_n), .start(start), .key(key), .wr_en(wr_en),
        .wr_idx(wr_idx), .wr_code(wr_code), .match(match_l), .done(done_l), .mline(mline_l));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Expected result from the position codes (bit1 true line, bit0 complement).
    function automatic logic exp_match(input logic [2*KW-1:0] pat, input logic [KW-1:0] k);
        logic ok = 1'b1;
        for (int i = 0; i < KW; i++) begin
            if ((pat[2*i+1] && k[i]) || (pat[2*i] && !k[i])) ok = 1'b0;
        end
        return ok;
    endfunction

    // Entered and left at a falling edge.
    task automatic wr(input int idx, input logic [1:0] code);
        wr_en = 1'b1; wr_idx = IW'(idx); wr_code = code;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load(input logic [2*KW-1:0] pat);
        for (int i = 0; i < KW; i++) wr(i, pat[2*i +: 2]);
    endtask

    task automatic search(input logic [KW-1:0] k, input logic exp, input string req);
        start = 1'b1; key = k;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(req, match, exp);
        chk(req, match_l, exp);
        chk("R5", done, 1'b1);
        chk("R6", mline, exp);
        chk("R6", mline_l, !exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state seen at the ports.
        chk("R1", match, 1'b0);
        chk("R1", done, 1'b0);
        chk("R1", mline, 1'b0);
        chk("R1", mline_l, 1'b1);
        search(4'b1010, 1'b1, "R1");

        // R5 and R6: phase-by-phase timing and line levels.
        load(8'b01_10_10_01);      // 1,0,0,1 MSB first
        start = 1'b1; key = 4'b1001;
        @(negedge clk);
        start = 1'b0;
        chk("R6", mline, 1'b1);
        chk("R6", mline_l, 1'b0);
        chk("R5", done, 1'b0);
        @(negedge clk);
        chk("R5", done, 1'b0);
        @(negedge clk);
        chk("R5", done, 1'b1);
        chk("R5", match, 1'b1);
        @(negedge clk);
        chk("R5", done, 1'b0);
        chk("R5", match, 1'b1);

        // R4: pattern 1,0,X,1 matches only 1001 and 1011.
        load(8'b01_10_00_01);
        for (int k = 0; k < 16; k++)
            search(KW'(k), (k == 9) || (k == 11), "R4");

        // R7: restart held high and key changed mid-search are both ignored.
        load(8'b00_00_00_01);      // position 0 must be 1
        start = 1'b1; key = 4'b0001;
        @(negedge clk);
        key = 4'b0000;
        @(negedge clk);
        @(negedge clk);
        start = 1'b0;
        chk("R7", done, 1'b1);
        chk("R7", match, 1'b1);
        @(negedge clk);
        chk("R7", done, 1'b0);
        @(negedge clk);
        chk("R7", done, 1'b0);

        // R8: write during a search is deferred to after completion.
        load(8'b00_00_00_00);
        start = 1'b1; key = 4'b0000;
        @(negedge clk);
        start = 1'b0;
        wr_en = 1'b1; wr_idx = 2'd0; wr_code = 2'b01;
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
        chk("R8", match, 1'b1);
        search(4'b0000, 1'b0, "R8");
        search(4'b0001, 1'b1, "R8");

        // R9: a never-match position rejects all keys.
        load(8'b00_11_00_00);
        for (int k = 0; k < 16; k++) search(KW'(k), 1'b0, "R9");

        // R2 and R3: every stored pattern against every key.
        for (int p = 0; p < 256; p++) begin
            load(8'(p));
            for (int k = 0; k < 16; k++)
                search(KW'(k), exp_match(8'(p), KW'(k)), "R3");
        end

        // R2: single-position encodings for stored 1 and stored 0.
        load(8'b00_00_01_00);
        search(4'b0010, 1'b1, "R2");
        search(4'b0000, 1'b0, "R2");
        load(8'b00_00_10_00);
        search(4'b0000, 1'b1, "R2");
        search(4'b0010, 1'b0, "R2");

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule